// File: doc/BRIEF.md
# Nested Prioritized Core Event Controller

This block arbitrates sixteen event levels for a processor core. Level 0 has the highest priority and level 15 the lowest. The roles are fixed: 0 emulation, 1 reset, 2 non-maskable interrupt, 3 exception, 4 a global-disable flag rather than an event, 5 hardware error, 6 timer, and 7 to 15 general interrupts. Requests arrive as single-cycle pulses, one line per level. A separate exception request carries a cause code. The controller records every request in a latch register. It enters a level when the acceptance rules allow it, and reports the entered level together with two hints for the core's program-counter logic: whether the vector-override register redirects the entry to the reset vector, and whether an exception should save the faulting instruction or the following one.

The pending register is the nesting stack. The current level is its lowest set bit, ignoring the emulation bit and bit 4. When none of those bits is set, the core is in user mode. Entering level 5 or lower priority sets bit 4, which blocks further maskable entries while the core is in supervisor mode. The core can clear bit 4 and set it again with two strobes, and it does so once it has saved its return address. Re-entry at the current level is allowed only while self-nesting is enabled. The entry is then flagged so that the core can mark the saved return address. On return, the core presents that mark, and a marked return leaves the pending bit set.

Returns are checked against the current level. A return that does not match raises an illegal-return pulse and changes nothing. A request for the non-maskable or exception level that arrives while the core is already at that level or higher raises a double-fault pulse instead of being entered.

Top module: `evt_ctrl`

## Requirements
- R1: After reset, pending reads 0x0012 (reset bit and bit 4), mask reads 0x001F, and latch, vector-override and priority registers read 0. All output pulses are low, and user_mode is low.
- R2: The register bus reads combinationally from bus_addr: 0 is vector override, 1 is mask, 2 is pending, 3 is latch, 4 is priority. A write takes effect at the clock edge. A write to the mask changes bits 15:5 and keeps bits 4:0 at one. A write to pending is ignored. The priority register keeps only bits 4:0 of the write. A write to the latch clears each bit written as one, restricted to mask 0xFFEE.
- R3: user_mode is high exactly when no pending bit other than bit 0 and bit 4 is set.
- R4: A request for level L in 5..15 that is accepted produces enter_valid with enter_level = L on the clock edge that samples the request. At that edge, pending bit L and bit 4 are set and latch bit L is cleared.
- R5: A request for level 5..15 is only latched when any of these holds: its mask bit is clear; bit 4 is set outside user mode; L is numerically greater than the current level; or L equals the current level while self_nest_en is low. A request on evt_req[4] is ignored.
- R6: A latched request is re-examined every cycle. It is entered on the edge after a mask write, a return, a nest_open strobe or a rise of self_nest_en makes it eligible.
- R7: When several requests are eligible in the same cycle, the lowest-numbered one is entered and the others stay latched.
- R8: Levels 0 and 1 are always entered. Level 2 or 3 is entered only when the current level is numerically greater. A new request for level 2 or 3 at an equal or higher current level pulses double_fault, leaves the level latched, and enters nothing.
- R9: exc_req is a request for level 3. On its entry, exc_at_fault is 1 when exc_cause is 0x20 or more and 0 otherwise.
- R10: On an entry, use_reset_vec equals vector-override bit L for L of 7 or more, and is 0 for L below 7.
- R11: enter_nested is 1 for an entry of level 5..15 at the current level. nest_open clears pending bit 4 and nest_close sets it.
- R12: ret_kind is 0 emulation, 1 non-maskable, 2 exception, 3 interrupt. An emulation return is legal only while pending bit 0 is set. A non-maskable return is legal only at level 2, an exception return only at level 3, and an interrupt return only outside user mode and not at level 2 or 3. An illegal return pulses illegal_ret and changes no register.
- R13: A legal return clears the pending bit of its level unless ret_nest is 1. It clears bit 4 when that level is 1 or 5..15. No entry is made in the cycle of a return request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_req | input | 16 | One-cycle request pulse per level |
| exc_req | input | 1 | Exception request (level 3) |
| exc_cause | input | 6 | Cause code of the exception request |
| ret_req | input | 1 | Return request strobe |
| ret_kind | input | 2 | Return type: 0 emulation, 1 non-maskable, 2 exception, 3 interrupt |
| ret_nest | input | 1 | Self-nesting mark of the saved return address |
| nest_open | input | 1 | Clear pending bit 4 (return address saved) |
| nest_close | input | 1 | Set pending bit 4 (return address restored) |
| self_nest_en | input | 1 | Allow re-entry at the current level |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| enter_valid | output | 1 | A level was entered |
| enter_level | output | 4 | Entered level |
| enter_nested | output | 1 | Entry at the current level (mark return address) |
| exc_at_fault | output | 1 | Exception entry saves the faulting instruction |
| use_reset_vec | output | 1 | Entry redirected to the reset vector |
| double_fault | output | 1 | Unrecoverable double-fault pulse |
| illegal_ret | output | 1 | Illegal-return pulse |
| user_mode | output | 1 | Core is in user mode |

## Verification
Entry outputs and the pulses double_fault and illegal_ret are registered. They appear on the edge that samples the request, so the bench drives a request after a falling edge and reads the result at the next falling edge. Register contents and user_mode follow the same edge and are read combinationally in that half cycle. An entry that becomes eligible because of a mask write or a return needs one more edge, so the bench first checks that enter_valid stays low after the change and then looks for the entry one cycle later. The nesting enable is combinational: the bench holds it high through one edge and expects the entry right after that edge.

// File: rtl/evt_ctrl_pkg.sv
package evt_ctrl_pkg;

  // Fixed level roles
  localparam int LV_EMU   = 0;
  localparam int LV_RST   = 1;
  localparam int LV_NMI   = 2;
  localparam int LV_EXC   = 3;
  localparam int LV_GDIS  = 4;
  localparam int LV_HWERR = 5;
  localparam int LV_OVR   = 7;   // first level the vector override applies to
  localparam int UNMASK_N = 5;   // levels 0..4 cannot be masked

  localparam int RA_W = 3;

  typedef enum logic [RA_W-1:0] {
    RA_VOVR  = 3'd0,
    RA_MASK  = 3'd1,
    RA_PEND  = 3'd2,
    RA_LATCH = 3'd3,
    RA_PRIO  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    RK_EMU = 2'd0,
    RK_NMI = 2'd1,
    RK_EXC = 2'd2,
    RK_INT = 2'd3
  } ret_kind_e;

endpackage

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_ctrl_pkg::*;
#(
  parameter int NUM_LVL = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [RA_W-1:0]    bus_addr,
  input  logic [NUM_LVL-1:0] bus_wdata,
  input  logic [NUM_LVL-1:0] pend_q,
  input  logic [NUM_LVL-1:0] latch_q,
  output logic [NUM_LVL-1:0] vovr_q,
  output logic [NUM_LVL-1:0] mask_q,
  output logic [NUM_LVL-1:0] prio_q,
  output logic [NUM_LVL-1:0] latch_clr,
  output logic [NUM_LVL-1:0] bus_rdata
);

  localparam logic [NUM_LVL-1:0] KEEP_BITS =
    {{(NUM_LVL-UNMASK_N){1'b0}}, {UNMASK_N{1'b1}}};
  localparam logic [NUM_LVL-1:0] CLR_OK =
    ~((NUM_LVL'(1) << LV_EMU) | (NUM_LVL'(1) << LV_GDIS));

  logic [NUM_LVL-1:0] vovr_d, mask_d, prio_d;
  logic               wr_vovr, wr_mask, wr_prio, wr_latch;

  always_comb begin
    wr_vovr  = bus_we && (bus_addr == RA_VOVR);
    wr_mask  = bus_we && (bus_addr == RA_MASK);
    wr_prio  = bus_we && (bus_addr == RA_PRIO);
    wr_latch = bus_we && (bus_addr == RA_LATCH);

    vovr_d = vovr_q;
    mask_d = mask_q;
    prio_d = prio_q;
    if (wr_vovr) vovr_d = bus_wdata;
    if (wr_mask) mask_d = (bus_wdata & ~KEEP_BITS) | KEEP_BITS;
    if (wr_prio) prio_d = bus_wdata & KEEP_BITS;
    latch_clr = wr_latch ? (bus_wdata & CLR_OK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vovr_q <= '0;
      mask_q <= KEEP_BITS;
      prio_q <= '0;
    end else begin
      if (wr_vovr) vovr_q <= vovr_d;
      if (wr_mask) mask_q <= mask_d;
      if (wr_prio) prio_q <= prio_d;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_VOVR:  bus_rdata = vovr_q;
      RA_MASK:  bus_rdata = mask_q;
      RA_PEND:  bus_rdata = pend_q;
      RA_LATCH: bus_rdata = latch_q;
      RA_PRIO:  bus_rdata = prio_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_ctrl_arb.sv
module evt_ctrl_arb
  import evt_ctrl_pkg::*;
#(
  parameter int NUM_LVL = 16,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               allow,
  input  logic               self_nest_en,
  input  logic [NUM_LVL-1:0] req_now,
  input  logic [NUM_LVL-1:0] lat_new,
  input  logic [NUM_LVL-1:0] mask_q,
  input  logic [NUM_LVL-1:0] pend_q,
  output logic [LVL_W:0]     cur_lvl,
  output logic               user_mode,
  output logic               take,
  output logic [LVL_W-1:0]   take_lvl,
  output logic               take_nested,
  output logic               dbl_fault
);

  logic [NUM_LVL-1:0] stack_bits;
  logic [NUM_LVL-1:0] cand;
  logic               gdis_block;

  // current level: lowest set bit, emulation and global-disable ignored
  always_comb begin
    stack_bits = pend_q & ~((NUM_LVL'(1) << LV_EMU) | (NUM_LVL'(1) << LV_GDIS));
    cur_lvl    = (LVL_W+1)'(NUM_LVL);
    for (int i = NUM_LVL-1; i >= 0; i--) begin
      if (stack_bits[i]) cur_lvl = (LVL_W+1)'(i);
    end
    user_mode  = (stack_bits == '0);
    gdis_block = pend_q[LV_GDIS] && !user_mode;
  end

  always_comb begin
    cand      = '0;
    dbl_fault = 1'b0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (i <= LV_RST) begin
        cand[i] = lat_new[i];
      end else if (i <= LV_EXC) begin
        cand[i] = lat_new[i] && (int'(cur_lvl) > i);
        if (req_now[i] && (int'(cur_lvl) <= i)) dbl_fault = allow;
      end else if (i == LV_GDIS) begin
        cand[i] = 1'b0;
      end else begin
        cand[i] = lat_new[i] && mask_q[i] && !gdis_block &&
                  ((i < int'(cur_lvl)) || (self_nest_en && (i == int'(cur_lvl))));
      end
    end
  end

  always_comb begin
    take_lvl = '0;
    for (int i = NUM_LVL-1; i >= 0; i--) begin
      if (cand[i]) take_lvl = LVL_W'(i);
    end
    take        = allow && (cand != '0);
    take_nested = (int'(take_lvl) >= LV_HWERR) &&
                  ({1'b0, take_lvl} == cur_lvl);
  end

endmodule

// File: rtl/evt_ctrl_retchk.sv
module evt_ctrl_retchk
  import evt_ctrl_pkg::*;
#(
  parameter int NUM_LVL = 16,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               ret_req,
  input  logic [1:0]         ret_kind,
  input  logic [NUM_LVL-1:0] pend_q,
  input  logic [LVL_W:0]     cur_lvl,
  input  logic               user_mode,
  output logic               ret_ok,
  output logic               ret_bad,
  output logic [LVL_W-1:0]   ret_lvl
);

  logic legal;

  always_comb begin
    legal   = 1'b0;
    ret_lvl = cur_lvl[LVL_W-1:0];
    case (ret_kind)
      RK_EMU: begin
        legal   = pend_q[LV_EMU];
        ret_lvl = LVL_W'(LV_EMU);
      end
      RK_NMI: begin
        legal   = (cur_lvl == (LVL_W+1)'(LV_NMI));
        ret_lvl = LVL_W'(LV_NMI);
      end
      RK_EXC: begin
        legal   = (cur_lvl == (LVL_W+1)'(LV_EXC));
        ret_lvl = LVL_W'(LV_EXC);
      end
      default: begin
        legal = !user_mode && (cur_lvl != (LVL_W+1)'(LV_NMI)) &&
                (cur_lvl != (LVL_W+1)'(LV_EXC));
      end
    endcase
    ret_ok  = ret_req && legal;
    ret_bad = ret_req && !legal;
  end

endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_ctrl_pkg::*;
#(
  parameter int NUM_LVL         = 16,
  parameter int CAUSE_W         = 6,
  parameter int FAULT_CAUSE_MIN = 'h20,
  parameter int LVL_W           = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] evt_req,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               ret_req,
  input  logic [1:0]         ret_kind,
  input  logic               ret_nest,
  input  logic               nest_open,
  input  logic               nest_close,
  input  logic               self_nest_en,
  input  logic               bus_we,
  input  logic [RA_W-1:0]    bus_addr,
  input  logic [NUM_LVL-1:0] bus_wdata,
  output logic [NUM_LVL-1:0] bus_rdata,
  output logic               enter_valid,
  output logic [LVL_W-1:0]   enter_level,
  output logic               enter_nested,
  output logic               exc_at_fault,
  output logic               use_reset_vec,
  output logic               double_fault,
  output logic               illegal_ret,
  output logic               user_mode
);

  localparam logic [NUM_LVL-1:0] PEND_RST =
    (NUM_LVL'(1) << LV_RST) | (NUM_LVL'(1) << LV_GDIS);

  logic [NUM_LVL-1:0] pend_q, pend_d;
  logic [NUM_LVL-1:0] latch_q, latch_d;
  logic [NUM_LVL-1:0] vovr_q, mask_q, prio_q, latch_clr;
  logic [NUM_LVL-1:0] req_now, lat_new;
  logic [LVL_W:0]     cur_lvl;
  logic               take, take_nested, dbl_fault;
  logic [LVL_W-1:0]   take_lvl;
  logic               ret_ok, ret_bad;
  logic [LVL_W-1:0]   ret_lvl;

  logic               ent_v_d, ent_n_d, ent_f_d, ent_r_d;

  evt_ctrl_regs #(.NUM_LVL(NUM_LVL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .latch_q   (latch_q),
    .vovr_q    (vovr_q),
    .mask_q    (mask_q),
    .prio_q    (prio_q),
    .latch_clr (latch_clr),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    req_now          = evt_req;
    req_now[LV_GDIS] = 1'b0;
    req_now[LV_EXC]  = evt_req[LV_EXC] | exc_req;
    lat_new          = (latch_q & ~latch_clr) | req_now;
  end

  evt_ctrl_arb #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_arb (
    .allow        (!ret_req),
    .self_nest_en (self_nest_en),
    .req_now      (req_now),
    .lat_new      (lat_new),
    .mask_q       (mask_q),
    .pend_q       (pend_q),
    .cur_lvl      (cur_lvl),
    .user_mode    (user_mode),
    .take         (take),
    .take_lvl     (take_lvl),
    .take_nested  (take_nested),
    .dbl_fault    (dbl_fault)
  );

  evt_ctrl_retchk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_ret (
    .ret_req   (ret_req),
    .ret_kind  (ret_kind),
    .pend_q    (pend_q),
    .cur_lvl   (cur_lvl),
    .user_mode (user_mode),
    .ret_ok    (ret_ok),
    .ret_bad   (ret_bad),
    .ret_lvl   (ret_lvl)
  );

  // next state
  always_comb begin
    latch_d = lat_new;
    pend_d  = pend_q;
    if (nest_open)  pend_d[LV_GDIS] = 1'b0;
    if (nest_close) pend_d[LV_GDIS] = 1'b1;
    if (ret_ok) begin
      if (!ret_nest) pend_d[ret_lvl] = 1'b0;
      if ((int'(ret_lvl) >= LV_HWERR) || (int'(ret_lvl) == LV_RST))
        pend_d[LV_GDIS] = 1'b0;
    end
    if (take) begin
      latch_d[take_lvl] = 1'b0;
      pend_d[take_lvl]  = 1'b1;
      if (int'(take_lvl) >= LV_HWERR) pend_d[LV_GDIS] = 1'b1;
    end
    ent_v_d = take;
    ent_n_d = take && take_nested;
    ent_f_d = take && (int'(take_lvl) == LV_EXC) &&
              (int'(exc_cause) >= FAULT_CAUSE_MIN);
    ent_r_d = take && (int'(take_lvl) >= LV_OVR) && vovr_q[take_lvl];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q        <= PEND_RST;
      latch_q       <= '0;
      enter_valid   <= 1'b0;
      enter_level   <= '0;
      enter_nested  <= 1'b0;
      exc_at_fault  <= 1'b0;
      use_reset_vec <= 1'b0;
      double_fault  <= 1'b0;
      illegal_ret   <= 1'b0;
    end else begin
      pend_q        <= pend_d;
      latch_q       <= latch_d;
      enter_valid   <= ent_v_d;
      if (take) enter_level <= take_lvl;
      enter_nested  <= ent_n_d;
      exc_at_fault  <= ent_f_d;
      use_reset_vec <= ent_r_d;
      double_fault  <= dbl_fault;
      illegal_ret   <= ret_bad;
    end
  end

endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk
  import evt_ctrl_pkg::*;
#(
  parameter int NUM_LVL = 16,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [RA_W-1:0]    bus_addr,
  input logic [NUM_LVL-1:0] bus_wdata,
  input logic               ret_req,
  input logic               nest_open,
  input logic               nest_close,
  input logic               enter_valid,
  input logic [LVL_W-1:0]   enter_level,
  input logic               double_fault,
  input logic               illegal_ret,
  input logic [NUM_LVL-1:0] pend_q,
  input logic [NUM_LVL-1:0] mask_q
);

  assert_enter_sets_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_valid |-> pend_q[enter_level]);

  assert_general_entry_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_valid && (int'(enter_level) >= LV_HWERR)) |-> pend_q[LV_GDIS]);

  assert_dblfault_no_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    double_fault |-> !(enter_valid && (int'(enter_level) >= LV_NMI)));

  assert_illegal_ret_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_ret && !$past(nest_open) && !$past(nest_close)) |-> (pend_q == $past(pend_q)));

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && (bus_addr == RA_MASK)) |->
      (mask_q[NUM_LVL-1:UNMASK_N] == $past(bus_wdata[NUM_LVL-1:UNMASK_N])));

  assert_ret_no_entry_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_req) |-> !enter_valid);

endmodule

bind evt_ctrl evt_ctrl_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .ret_req      (ret_req),
  .nest_open    (nest_open),
  .nest_close   (nest_close),
  .enter_valid  (enter_valid),
  .enter_level  (enter_level),
  .double_fault (double_fault),
  .illegal_ret  (illegal_ret),
  .pend_q       (pend_q),
  .mask_q       (mask_q)
);

// File: tb/evt_ctrl_bench.sv
module evt_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] evt_req;
  logic        exc_req;
  logic [5:0]  exc_cause;
  logic        ret_req;
  logic [1:0]  ret_kind;
  logic        ret_nest;
  logic        nest_open, nest_close, self_nest_en;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        enter_valid;
  logic [3:0]  enter_level;
  logic        enter_nested, exc_at_fault, use_reset_vec;
  logic        double_fault, illegal_ret, user_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  evt_ctrl u_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .exc_req(exc_req),
    .exc_cause(exc_cause), .ret_req(ret_req), .ret_kind(ret_kind),
    .ret_nest(ret_nest), .nest_open(nest_open), .nest_close(nest_close),
    .self_nest_en(self_nest_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enter_valid(enter_valid),
    .enter_level(enter_level), .enter_nested(enter_nested),
    .exc_at_fault(exc_at_fault), .use_reset_vec(use_reset_vec),
    .double_fault(double_fault), .illegal_ret(illegal_ret),
    .user_mode(user_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [2:0] A_VOVR = 3'd0, A_MASK = 3'd1, A_PEND = 3'd2,
                         A_LATCH = 3'd3, A_PRIO = 3'd4;
  localparam logic [1:0] K_EMU = 2'd0, K_NMI = 2'd1, K_EXC = 2'd2, K_INT = 2'd3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {16'h0, bus_rdata}, {16'h0, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] m);
    evt_req = m;
    tick();
    evt_req = '0;
  endtask

  task automatic do_ret(input logic [1:0] k, input logic nst);
    ret_req = 1'b1; ret_kind = k; ret_nest = nst;
    tick();
    ret_req = 1'b0; ret_nest = 1'b0;
  endtask

  task automatic chk_enter(input string tag, input logic v, input int lvl);
    chk({tag, " enter_valid"}, {31'h0, enter_valid}, {31'h0, v});
    if (v) chk({tag, " enter_level"}, {28'h0, enter_level}, lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_req = '0; exc_req = 1'b0; exc_cause = '0;
    ret_req = 1'b0; ret_kind = '0; ret_nest = 1'b0; nest_open = 1'b0;
    nest_close = 1'b0; self_nest_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk_reg("R1 pending", A_PEND, 16'h0012);
    chk_reg("R1 mask", A_MASK, 16'h001F);
    chk_reg("R1 latch", A_LATCH, 16'h0000);
    chk_reg("R1 vovr", A_VOVR, 16'h0000);
    chk_reg("R1 prio", A_PRIO, 16'h0000);
    chk("R1 enter_valid", {31'h0, enter_valid}, 0);
    chk("R1 double_fault", {31'h0, double_fault}, 0);
    chk("R1 user_mode", {31'h0, user_mode}, 0);

    // R12 exception return at level 1 is illegal
    do_ret(K_EXC, 1'b0);
    chk("R12 illegal exc ret at reset", {31'h0, illegal_ret}, 1);
    chk_reg("R12 pending unchanged", A_PEND, 16'h0012);

    // R13 leave reset level by interrupt return
    do_ret(K_INT, 1'b0);
    chk("R13 boot ret legal", {31'h0, illegal_ret}, 0);
    chk_reg("R13 pending after boot", A_PEND, 16'h0000);
    chk("R3 user after boot", {31'h0, user_mode}, 1);

    // R12 return from user mode
    do_ret(K_INT, 1'b0);
    chk("R12 ret from user", {31'h0, illegal_ret}, 1);
    chk_reg("R12 pending user", A_PEND, 16'h0000);

    // R2 register bus
    wr(A_MASK, 16'h0000);
    chk_reg("R2 mask keeps unmaskable", A_MASK, 16'h001F);
    wr(A_PEND, 16'hFFFF);
    chk_reg("R2 pending read-only", A_PEND, 16'h0000);
    wr(A_PRIO, 16'hFFFF);
    chk_reg("R2 prio field", A_PRIO, 16'h001F);
    wr(A_PRIO, 16'h0000);

    // R5 masked request only latches
    pulse(16'h0100);
    chk_enter("R5 masked", 1'b0, 0);
    chk_reg("R5 masked latch", A_LATCH, 16'h0100);
    chk_reg("R5 masked pending", A_PEND, 16'h0000);

    // R6 mask write triggers entry one cycle later
    wr(A_MASK, 16'hFFFF);
    chk_enter("R6 no entry in write cycle", 1'b0, 0);
    chk_reg("R2 mask all", A_MASK, 16'hFFFF);
    tick();
    chk_enter("R6 entry after mask write", 1'b1, 8);
    chk_reg("R6 latch cleared", A_LATCH, 16'h0000);
    chk_reg("R4 pending lvl8", A_PEND, 16'h0110);
    do_ret(K_INT, 1'b0);
    chk_reg("R13 pending after ret8", A_PEND, 16'h0000);

    // R4 / R10 sweep over general levels with two override patterns
    for (int p = 0; p < 2; p++) begin
      logic [15:0] ov;
      ov = (p == 0) ? 16'hA5F0 : 16'h5A0F;
      wr(A_VOVR, ov);
      for (int l = 5; l < 16; l++) begin
        pulse(16'(1 << l));
        chk_enter($sformatf("R4 sweep lvl%0d", l), 1'b1, l);
        chk($sformatf("R11 sweep nested lvl%0d", l), {31'h0, enter_nested}, 0);
        chk($sformatf("R10 reset vec lvl%0d", l), {31'h0, use_reset_vec},
            ((l >= 7) && ov[l]) ? 1 : 0);
        chk_reg($sformatf("R4 pending lvl%0d", l), A_PEND, 16'(1 << l) | 16'h0010);
        chk("R3 supervisor", {31'h0, user_mode}, 0);
        do_ret(K_INT, 1'b0);
        chk_reg($sformatf("R13 ret lvl%0d", l), A_PEND, 16'h0000);
      end
    end
    wr(A_VOVR, 16'h0000);

    // R7 simultaneous requests
    pulse(16'h1200);
    chk_enter("R7 lowest wins", 1'b1, 9);
    chk_reg("R7 other latched", A_LATCH, 16'h1000);
    // R5 global disable blocks higher priority
    pulse(16'h0040);
    chk_enter("R5 gdis blocks", 1'b0, 0);
    chk_reg("R5 gdis latch", A_LATCH, 16'h1040);
    do_ret(K_INT, 1'b0);
    chk_enter("R13 no entry in ret cycle", 1'b0, 0);
    tick();
    chk_enter("R6 latched 6 after ret", 1'b1, 6);
    chk_reg("R7 latch keeps 12", A_LATCH, 16'h1000);
    chk_reg("R4 pending 6", A_PEND, 16'h0050);
    do_ret(K_INT, 1'b0);
    tick();
    chk_enter("R6 latched 12 after ret", 1'b1, 12);
    do_ret(K_INT, 1'b0);
    chk_reg("R13 back to user", A_PEND, 16'h0000);

    // R11 self-nesting
    pulse(16'h0400);
    chk_enter("R11 enter 10", 1'b1, 10);
    nest_open = 1'b1; tick(); nest_open = 1'b0;
    chk_reg("R11 nest_open clears bit4", A_PEND, 16'h0400);
    pulse(16'h1000);
    chk_enter("R5 lower priority", 1'b0, 0);
    chk_reg("R5 lower latched", A_LATCH, 16'h1000);
    wr(A_LATCH, 16'h1000);
    chk_reg("R2 latch w1c", A_LATCH, 16'h0000);
    pulse(16'h0400);
    chk_enter("R5 equal without nesting", 1'b0, 0);
    chk_reg("R5 equal latched", A_LATCH, 16'h0400);
    self_nest_en = 1'b1; tick(); self_nest_en = 1'b0;
    chk_enter("R11 self nest entry", 1'b1, 10);
    chk("R11 nested flag", {31'h0, enter_nested}, 1);
    chk_reg("R11 pending nested", A_PEND, 16'h0410);
    chk_reg("R11 latch cleared", A_LATCH, 16'h0000);
    nest_open = 1'b1; tick(); nest_open = 1'b0;
    nest_close = 1'b1; tick(); nest_close = 1'b0;
    chk_reg("R11 nest_close sets bit4", A_PEND, 16'h0410);
    do_ret(K_INT, 1'b1);
    chk_reg("R13 marked ret keeps bit", A_PEND, 16'h0400);
    do_ret(K_INT, 1'b0);
    chk_reg("R13 final ret", A_PEND, 16'h0000);

    // R9 / R8 exceptions
    exc_req = 1'b1; exc_cause = 6'h05; tick(); exc_req = 1'b0;
    chk_enter("R9 exc entry", 1'b1, 3);
    chk("R9 service cause", {31'h0, exc_at_fault}, 0);
    chk_reg("R9 pending exc no bit4", A_PEND, 16'h0008);
    exc_req = 1'b1; exc_cause = 6'h25; tick(); exc_req = 1'b0;
    chk("R8 double fault", {31'h0, double_fault}, 1);
    chk_enter("R8 no entry on dbl", 1'b0, 0);
    chk_reg("R8 dbl latched", A_LATCH, 16'h0008);
    wr(A_LATCH, 16'h0008);
    chk_reg("R2 clear latched exc", A_LATCH, 16'h0000);
    do_ret(K_NMI, 1'b0);
    chk("R12 nmi ret at 3", {31'h0, illegal_ret}, 1);
    do_ret(K_EXC, 1'b0);
    chk_reg("R13 exc ret", A_PEND, 16'h0000);
    exc_req = 1'b1; exc_cause = 6'h25; tick(); exc_req = 1'b0;
    chk_enter("R9 fault exc entry", 1'b1, 3);
    chk("R9 fault cause", {31'h0, exc_at_fault}, 1);
    do_ret(K_EXC, 1'b0);

    // R8 non-maskable over general level, emulation over all
    pulse(16'h0100);
    pulse(16'h0004);
    chk_enter("R8 nmi enters despite bit4", 1'b1, 2);
    chk_reg("R8 pending nmi", A_PEND, 16'h0114);
    pulse(16'h0004);
    chk("R8 nmi dbl", {31'h0, double_fault}, 1);
    chk_reg("R8 nmi latched", A_LATCH, 16'h0004);
    wr(A_LATCH, 16'hFFFF);
    chk_reg("R2 w1c all", A_LATCH, 16'h0000);
    pulse(16'h0001);
    chk_enter("R8 emu always", 1'b1, 0);
    chk_reg("R8 pending emu", A_PEND, 16'h0115);
    do_ret(K_EMU, 1'b0);
    chk_reg("R13 emu ret", A_PEND, 16'h0114);
    do_ret(K_EXC, 1'b0);
    chk("R12 exc ret at 2", {31'h0, illegal_ret}, 1);
    do_ret(K_NMI, 1'b0);
    chk_reg("R13 nmi ret", A_PEND, 16'h0110);
    do_ret(K_INT, 1'b0);
    chk_reg("R13 ret 8", A_PEND, 16'h0000);

    // R3 emulation from user keeps user_mode, reset level clears bit4
    pulse(16'h0001);
    chk_enter("R8 emu from user", 1'b1, 0);
    chk("R3 user with emu", {31'h0, user_mode}, 1);
    do_ret(K_EMU, 1'b0);
    chk_reg("R13 emu ret user", A_PEND, 16'h0000);
    pulse(16'h0002);
    chk_enter("R8 reset level", 1'b1, 1);
    nest_close = 1'b1; tick(); nest_close = 1'b0;
    chk_reg("R11 bit4 at reset lvl", A_PEND, 16'h0012);
    do_ret(K_INT, 1'b0);
    chk_reg("R13 reset ret clears bit4", A_PEND, 16'h0000);

    // R5 ignored level-4 request, R13 return blocks same-cycle entry
    pulse(16'h0010);
    chk_enter("R5 lvl4 ignored", 1'b0, 0);
    chk_reg("R5 lvl4 not latched", A_LATCH, 16'h0000);
    pulse(16'h0100);
    evt_req = 16'h0080;
    do_ret(K_INT, 1'b0);
    evt_req = '0;
    chk_enter("R13 ret cycle no entry", 1'b0, 0);
    chk_reg("R13 ret cleared 8", A_PEND, 16'h0000);
    tick();
    chk_enter("R6 enter 7 after ret", 1'b1, 7);
    do_ret(K_INT, 1'b0);
    chk_reg("R13 end", A_PEND, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule